// File: doc/BRIEF.md
# Range TLB Invalidation Matcher

This block removes translations from a small, fully associative TLB in answer to a range-invalidate request. The request carries one 64-bit operand that packs a granule code, a scale exponent, a count, a level hint and a base page field. From these the block derives a virtual-address window that starts at the base and spans (count+1)·2^(5·scale+1) granules. It then visits one TLB entry per clock. Any valid leaf entry that was built with the requested granule, agrees with the level hint and lies inside the window is cleared.

The TLB is loaded through a fill port that writes one entry per cycle. A probe port reads back the valid bit, ASID and global flag of any entry, so the rest of the pipeline and the bench can see which translations remain. Requests use a valid/ready handshake. `done` pulses for one cycle when a request has finished. The ASID and global flag play no part in matching, so both global and non-global entries of every ASID are removed.

Top module: `range_tlbi_matcher`

## Requirements
- R1: After a synchronous reset, every entry is invalid, `req_ready` is 1 and `done` is 0.
- R2: A fill writes the addressed entry and marks it valid. The probe port then returns valid=1 with the filled ASID and global flag.
- R3: The operand holds granule code in [47:46], scale in [45:44], count in [43:39], level hint in [38:37] and base field in [36:0]. Granule code 01 is 4 KB and the base field supplies VA[48:12]. Code 10 is 16 KB with VA[50:14]. Code 11 is 64 KB with VA[52:16]. A matching entry is cleared when base ≤ VA < base + (count+1)·2^(5·scale+1)·granule, and entries outside that window keep their valid bit.
- R4: An entry whose stored granule code differs from the requested one is not cleared.
- R5: Level hint 00 matches a leaf at any level. Hints 01, 10 and 11 clear only leaves whose stored level is 1, 2 or 3 respectively.
- R6: With the 16 KB granule, level hint 01 is treated as 00 (any level).
- R7: Entries whose leaf flag is 0 are never cleared.
- R8: The ASID and global flag do not influence matching.
- R9: Granule code 00 is reserved. The request is accepted, `done` pulses in the next cycle and no entry is cleared.
- R10: For a non-reserved request, `req_ready` is 0 from the cycle after acceptance until the scan ends. `done` is high for exactly one cycle, ENTRIES cycles after the accepting edge, and `req_ready` is 1 again in that cycle.
- R11: Operand bits [63:48] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Invalidate request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 64 | Range-invalidate operand |
| done | output | 1 | One-cycle pulse when a request completes |
| fill_valid | input | 1 | Write an entry this cycle |
| fill_idx | input | $clog2(ENTRIES) | Entry to write |
| fill_vpn | input | 41 | VA[52:12] of the entry |
| fill_gran | input | 2 | Granule code the entry was built with |
| fill_level | input | 2 | Table level of the entry |
| fill_leaf | input | 1 | Entry is a leaf (last-level) descriptor |
| fill_asid | input | ASID_W | Address-space identifier |
| fill_global | input | 1 | Entry is global |
| probe_idx | input | $clog2(ENTRIES) | Entry to read back |
| probe_valid | output | 1 | Valid bit of the probed entry |
| probe_asid | output | ASID_W | ASID of the probed entry |
| probe_global | output | 1 | Global flag of the probed entry |

## Verification
A wrong latched window, granule or level hint shows up as a wrong valid bit on the probe port right after `done`. A scan counter that is off by one moves the `done` pulse by a cycle, or leaves the last entry untouched. A bad handshake state shows up in `req_ready` in the cycle after acceptance, and a stuck `done` shows up one cycle after its pulse. The bench mirrors the TLB and works out the expected window in byte addresses, then compares every entry after each request. Any divergence therefore appears within one request.

// File: rtl/range_tlbi_matcher.sv
module range_tlbi_matcher #(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PG_W   = 41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_op,
  output logic              done,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [PG_W-1:0]   fill_vpn,
  input  logic [1:0]        fill_gran,
  input  logic [1:0]        fill_level,
  input  logic              fill_leaf,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              probe_valid,
  output logic [ASID_W-1:0] probe_asid,
  output logic              probe_global
);

  logic [ENTRIES-1:0] ent_valid, ent_leaf;
  logic [PG_W-1:0]    ent_vpn  [ENTRIES];
  logic [1:0]         ent_gran [ENTRIES];
  logic [1:0]         ent_lvl  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [ENTRIES-1:0] ent_glb;

  logic             busy;
  logic [IDX_W-1:0] scan_idx;
  logic [1:0]       tg_q, ttl_q;
  logic [PG_W-1:0]  base_q;
  logic [PG_W:0]    lim_q;

  wire unused_hi = ^req_op[63:48];

  logic [1:0]      req_tg, req_scale, req_ttl;
  logic [5:0]      req_cnt;
  logic [2:0]      req_gsh;
  logic [4:0]      req_exp;
  logic [PG_W-1:0] req_base;
  logic [PG_W:0]   req_span, req_lim;

  assign req_tg    = req_op[47:46];
  assign req_scale = req_op[45:44];
  assign req_cnt   = {1'b0, req_op[43:39]} + 6'd1;
  assign req_ttl   = (req_tg == 2'b10 && req_op[38:37] == 2'b01) ? 2'b00 : req_op[38:37];
  assign req_gsh   = (req_tg == 2'b01) ? 3'd0 : (req_tg == 2'b10) ? 3'd2 : 3'd4;
  assign req_exp   = 5'd5 * {3'b0, req_scale} + 5'd1 + {2'b0, req_gsh};
  assign req_base  = {4'b0, req_op[36:0]} << req_gsh;
  assign req_span  = {36'b0, req_cnt} << req_exp;
  assign req_lim   = {1'b0, req_base} + req_span;

  assign req_ready = !busy;
  wire accept = req_valid && req_ready;

  logic [PG_W-1:0] sel_vpn;
  logic            hit, last;
  assign sel_vpn = ent_vpn[scan_idx];
  assign last    = scan_idx == IDX_W'(ENTRIES - 1);
  assign hit = ent_valid[scan_idx] && ent_leaf[scan_idx]
            && ent_gran[scan_idx] == tg_q
            && (ttl_q == 2'b00 || ent_lvl[scan_idx] == ttl_q)
            && sel_vpn >= base_q && {1'b0, sel_vpn} < lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      scan_idx  <= '0;
      ent_valid <= '0;
      ent_leaf  <= '0;
      tg_q      <= 2'b00;
      ttl_q     <= 2'b00;
      base_q    <= '0;
      lim_q     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        scan_idx <= '0;
        tg_q     <= req_tg;
        ttl_q    <= req_ttl;
        base_q   <= req_base;
        lim_q    <= req_lim;
        if (req_tg == 2'b00) done <= 1'b1;
        else                 busy <= 1'b1;
      end else if (busy) begin
        if (hit) ent_valid[scan_idx] <= 1'b0;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
      end
      if (fill_valid) begin
        ent_valid[fill_idx] <= 1'b1;
        ent_leaf[fill_idx]  <= fill_leaf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      ent_vpn[fill_idx]  <= fill_vpn;
      ent_gran[fill_idx] <= fill_gran;
      ent_lvl[fill_idx]  <= fill_level;
      ent_asid[fill_idx] <= fill_asid;
      ent_glb[fill_idx]  <= fill_global;
    end
  end

  assign probe_valid  = ent_valid[probe_idx];
  assign probe_asid   = ent_asid[probe_idx];
  assign probe_global = ent_glb[probe_idx];

endmodule

// File: rtl/range_tlbi_checker.sv
module range_tlbi_checker #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_tg,
  input logic               done,
  input logic               busy,
  input logic [IDX_W-1:0]   scan_idx,
  input logic [ENTRIES-1:0] valid_v,
  input logic [ENTRIES-1:0] leaf_v,
  input logic               fill_valid
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done && req_ready && valid_v == '0));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_tg != 2'b00) |=> !req_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !(req_valid && req_ready && req_tg == 2'b00)) |=> !done);

  assert_reserved_done_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_tg == 2'b00) |=> done);

  assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !fill_valid) |=> valid_v == $past(valid_v));

  assert_nonleaf_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !leaf_v[scan_idx] && !fill_valid) |=> valid_v == $past(valid_v));

endmodule

bind range_tlbi_matcher range_tlbi_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_tg(req_op[47:46]), .done(done), .busy(busy), .scan_idx(scan_idx),
  .valid_v(ent_valid), .leaf_v(ent_leaf), .fill_valid(fill_valid)
);

// File: tb/sim_range_tlbi_matcher.sv
module sim_range_tlbi_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int IW = $clog2(N);

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, done;
  logic [63:0] req_op = '0;
  logic fill_valid = 0, fill_leaf = 0, fill_global = 0;
  logic [IW-1:0] fill_idx = '0, probe_idx = '0;
  logic [40:0] fill_vpn = '0;
  logic [1:0] fill_gran = '0, fill_level = '0;
  logic [AW-1:0] fill_asid = '0, probe_asid;
  logic probe_valid, probe_global;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_tlbi_matcher #(.ENTRIES(N), .ASID_W(AW)) u0 (
    .clk, .rst, .req_valid, .req_ready, .req_op, .done,
    .fill_valid, .fill_idx, .fill_vpn, .fill_gran, .fill_level, .fill_leaf,
    .fill_asid, .fill_global, .probe_idx, .probe_valid, .probe_asid, .probe_global);

  int n_chk = 0, n_bad = 0;
  logic [40:0] m_vpn [N];
  logic [1:0]  m_gran [N], m_lvl [N];
  logic        m_leaf [N], m_valid [N];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(int i, logic [63:0] op);
    logic [1:0] tg, ttl;
    int gsh;
    logic [63:0] base, size, va;
    tg = op[47:46];
    if (tg == 2'b00) return 0;
    gsh = (tg == 2'b01) ? 12 : (tg == 2'b10) ? 14 : 16;
    base = {27'b0, op[36:0]} << gsh;
    size = (64'(op[43:39]) + 64'd1) << (5 * int'(op[45:44]) + 1);
    size = size << gsh;
    ttl = op[38:37];
    if (tg == 2'b10 && ttl == 2'b01) ttl = 2'b00;
    va = {11'b0, m_vpn[i], 12'b0};
    return m_valid[i] && m_leaf[i] && m_gran[i] == tg
        && (ttl == 2'b00 || m_lvl[i] == ttl) && va >= base && va < base + size;
  endfunction

  task automatic fill(int i, logic [63:0] va, logic [1:0] g, logic [1:0] l,
                      logic lf, logic [AW-1:0] a, logic gb);
    @(negedge clk);
    fill_valid = 1; fill_idx = IW'(i); fill_vpn = va[52:12];
    fill_gran = g; fill_level = l; fill_leaf = lf; fill_asid = a; fill_global = gb;
    @(negedge clk);
    fill_valid = 0;
    m_vpn[i] = va[52:12]; m_gran[i] = g; m_lvl[i] = l; m_leaf[i] = lf; m_valid[i] = 1;
    probe_idx = IW'(i);
    #1;
    chk("R2 fill valid", 64'(probe_valid), 64'd1);
    chk("R2 fill asid", 64'(probe_asid), 64'(a));
    chk("R2 fill global", 64'(probe_global), 64'(gb));
  endtask

  task automatic run_op(logic [63:0] op, string tag);
    bit exp [N];
    int cyc;
    for (int i = 0; i < N; i++) exp[i] = m_valid[i] && !exp_hit(i, op);
    @(negedge clk);
    chk("R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1; req_op = op;
    @(posedge clk); #1;
    req_valid = 0;
    cyc = 0;
    if (op[47:46] == 2'b00) begin
      chk("R9 reserved done next cycle", 64'(done), 64'd1);
    end else begin
      chk("R10 ready low after accept", 64'(req_ready), 64'd0);
      while (!done && cyc < 4 * N) begin
        @(posedge clk); #1; cyc++;
      end
      chk("R10 done latency", 64'(cyc), 64'(N));
      chk("R10 ready back with done", 64'(req_ready), 64'd1);
    end
    @(posedge clk); #1;
    chk("R10 done single pulse", 64'(done), 64'd0);
    for (int i = 0; i < N; i++) begin
      probe_idx = IW'(i); #1;
      chk(tag, 64'(probe_valid), 64'(exp[i]));
      m_valid[i] = exp[i];
    end
  endtask

  function automatic logic [63:0] mk_op(logic [1:0] tg, logic [1:0] sc, logic [4:0] num,
                                        logic [1:0] ttl, logic [36:0] base);
    return {16'h0, tg, sc, num, ttl, base};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] op, bva, sz, va;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 done after reset", 64'(done), 64'd0);
    for (int i = 0; i < N; i++) begin
      probe_idx = IW'(i); #1;
      chk("R1 entry invalid", 64'(probe_valid), 64'd0);
    end

    // 4K window: pages 0x100..0x107
    fill(0, 64'h0FF << 12, 2'b01, 2'd3, 1, 16'h1111, 0);
    fill(1, 64'h100 << 12, 2'b01, 2'd3, 1, 16'h2222, 0);
    fill(2, 64'h107 << 12, 2'b01, 2'd3, 1, 16'h3333, 1);
    fill(3, 64'h108 << 12, 2'b01, 2'd3, 1, 16'h4444, 0);
    fill(4, 64'h104 << 12, 2'b01, 2'd2, 1, 16'h5555, 0);
    fill(5, 64'h105 << 12, 2'b01, 2'd3, 0, 16'h6666, 0);
    fill(6, 64'h104 << 12, 2'b10, 2'd3, 1, 16'h7777, 0);
    fill(7, 64'h106 << 12, 2'b01, 2'd3, 1, 16'hABCD, 1);
    run_op(mk_op(2'b01, 2'd0, 5'd3, 2'b11, 37'h100), "R3 R4 R5 R7 R8 directed 4K");

    // reserved granule clears nothing
    fill(1, 64'h100 << 12, 2'b01, 2'd3, 1, 16'h2222, 0);
    run_op(mk_op(2'b00, 2'd0, 5'd3, 2'b00, 37'h100), "R9 reserved keeps entries");

    // 16K with hint 01 acts as any level
    fill(0, 64'h40 << 14, 2'b10, 2'd2, 1, 16'h1, 0);
    fill(1, 64'h41 << 14, 2'b10, 2'd3, 1, 16'h2, 1);
    run_op(mk_op(2'b10, 2'd0, 5'd0, 2'b01, 37'h40), "R6 16K hint 01 any level");

    // upper bits ignored, 64K maximal window
    fill(2, 64'h10 << 16, 2'b11, 2'd1, 1, 16'h3, 0);
    fill(3, (64'h10 << 16) + (64'd2 << 36) - 64'h10000, 2'b11, 2'd3, 1, 16'h4, 0);
    fill(4, (64'h10 << 16) + (64'd2 << 36), 2'b11, 2'd3, 1, 16'h5, 0);
    op = mk_op(2'b11, 2'd3, 5'd31, 2'b00, 37'h10);
    op[63:48] = 16'hBEEF;
    run_op(op, "R3 R11 64K max window with high bits");

    for (int it = 0; it < 40; it++) begin
      logic [1:0] tg;
      int gsh;
      tg = 2'($urandom_range(1, 3));
      if ($urandom_range(0, 9) == 0) tg = 2'b00;
      op = mk_op(tg, 2'($urandom), 5'($urandom), 2'($urandom),
                 37'($urandom_range(0, 32'hFFFFF)) | (37'd1 << 21));
      op[63:48] = 16'($urandom);
      gsh = (tg == 2'b01) ? 12 : (tg == 2'b10) ? 14 : 16;
      bva = {27'b0, op[36:0]} << gsh;
      sz  = ((64'(op[43:39]) + 64'd1) << (5 * int'(op[45:44]) + 1)) << gsh;
      for (int i = 0; i < N; i++) begin
        logic [1:0] g;
        int eg;
        g = ($urandom_range(0, 3) == 0) ? 2'($urandom) : tg;
        eg = (g == 2'b10) ? 14 : (g == 2'b11) ? 16 : 12;
        va = bva - (sz >> 2) + 64'($urandom) % (sz + (sz >> 1) + 64'd1);
        if ($urandom_range(0, 5) == 0) va = bva + sz - ($urandom_range(0, 1) << eg);
        va = (va >> eg) << eg;
        fill(i, va, g, 2'($urandom), $urandom_range(0, 3) != 0,
             AW'($urandom), 1'($urandom));
      end
      run_op(op, "R3 R4 R5 R6 R7 R8 R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule